// File: doc/BRIEF.md
# Interrupt Acceptance and Return Sequencer

This block is the interrupt front end of a small 8-bit processor core with a 16-bit program counter. It holds one request latch per maskable source plus one for a non-maskable source. Maskable sources are qualified by a per-source enable input and by a global interrupt enable flag kept inside the block. When a source is eligible and the block is idle, it picks a winner and runs a fixed bus sequence. The sequence writes the return address and status byte to a byte-wide stack that grows downward, reads a two-byte entry address from the vector table, and hands that address to the core.

A return command runs the opposite sequence. It reads the three stacked bytes back, restores the program counter, the status byte and the global enable flag, and moves the stack pointer up by three. While either sequence runs, `busy` is high so that the core holds its instruction fetch. The stack pointer is reset to `SP_INIT`. Vector slot k (slot 0 is the non-maskable source, slot i+1 is maskable source i) sits at byte address `VEC_TOP - 2 - 2*k`.

Top module: `irq_accept_seq`

## Requirements
- R1: A maskable source is never accepted while the global enable `imf` is 0, whatever its priority.
- R2: A maskable source whose `src_en` bit is 0 is not accepted. Its latch stays set and it is accepted once the bit becomes 1 while `imf` is 1.
- R3: The non-maskable request is accepted regardless of `imf` and `src_en`, and wins over every maskable source.
- R4: Among eligible maskable sources, the lowest index is accepted first.
- R5: In the acceptance cycle `imf` is cleared and the winner's latch is cleared. The stacked status byte carries the pre-acceptance `imf` in bit 7 and `psw_flags_in` in bits 6..0.
- R6: Acceptance with stack pointer n writes PC[15:8] at n, PC[7:0] at n-1 and the status byte at n-2, in three consecutive cycles starting the cycle after acceptance. After that the stack pointer is n-3.
- R7: The two following cycles read the slot's vector address and that address plus one, low byte first. In the next cycle `pc_load` pulses for one cycle with `pc_out` = {byte at address+1, byte at address}.
- R8: A return with stack pointer n reads n+1 (status), n+2 (PC low) and n+3 (PC high) in three consecutive cycles. In the next cycle `pc_load` and `psw_load` pulse with the restored values, `imf` equals the restored bit 7, and the stack pointer is n+3.
- R9: `busy` is high for exactly the 6 cycles of an acceptance and the 4 cycles of a return. A return command while busy is ignored. A return command in an idle cycle wins over a pending eligible source, which is accepted after the return.
- R10: A pending non-maskable request starts acceptance within 38 cycles of its latch being set.
- R11: After reset the stack pointer is `SP_INIT`, `imf` is 0, no request is pending and `busy` is 0.
- R12: `imf_set` sets `imf` and `imf_clr` clears it, one cycle later. Acceptance and restore take precedence over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NSRC | Maskable request pulses, one per source |
| nmi_req | input | 1 | Non-maskable request pulse |
| src_en | input | NSRC | Per-source enable flags |
| imf_set | input | 1 | Set global enable |
| imf_clr | input | 1 | Clear global enable |
| reti | input | 1 | Return-from-interrupt command |
| pc_in | input | 16 | Return address to save |
| psw_flags_in | input | 7 | Status flags to save (bit 7 comes from `imf`) |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_re` |
| mem_addr | output | 16 | Bus address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Load `pc_out` into the core |
| psw_out | output | 8 | Restored status byte |
| psw_load | output | 1 | Load `psw_out` into the core |
| imf | output | 1 | Global interrupt enable flag |
| busy | output | 1 | Sequence in progress, hold fetch |
| sp | output | 16 | Stack pointer |

## Verification
The bench tries single requests with the global flag first off and then on, which separates the flag gate from the latch. Simultaneous requests with one source disabled show that per-source enables, rather than priority alone, decide the winner. A pair of enabled simultaneous requests exposes the index order. Non-maskable requests are issued with the flag cleared and again together with pending maskable work, which tells the bypass apart from plain priority. Returns are issued during a sequence and in the same cycle as a newly eligible source, which shows whether commands are dropped or ordered correctly. Every bus cycle, stack pointer value and flag value is compared with a queue-based model each clock.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_HI,
    S_PUSH_LO,
    S_PUSH_PSW,
    S_VEC_LO,
    S_VEC_HI,
    S_ENTER,
    S_POP_PSW,
    S_POP_LO,
    S_POP_HI,
    S_LEAVE
  } seq_state_t;

  localparam int FRAME_BYTES = 3;
endpackage

// File: rtl/iseq_pend.sv
module iseq_pend #(
  parameter int NSRC = 4,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            nmi_req,
  input  logic [NSRC-1:0] en,
  input  logic            imf,
  input  logic            take,
  output logic            pend_ok,
  output logic            win_nmi,
  output logic [IW-1:0]   win_idx
);
  localparam int LAT_LIMIT = 38;

  logic [NSRC-1:0] lat_q, lat_d, elig, clr;
  logic            nmi_q, nmi_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign elig[i] = lat_q[i] & en[i] & imf;
    assign clr[i]  = take & ~nmi_q & (win_idx == IW'(i));
    assign lat_d[i] = (lat_q[i] & ~clr[i]) | req[i];
  end

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = IW'(i);
    end
  end

  assign win_nmi = nmi_q;
  assign pend_ok = nmi_q | (|elig);
  assign nmi_d   = (nmi_q & ~take) | nmi_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      nmi_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      nmi_q <= nmi_d;
    end
  end

  // wait counter for the non-maskable latency bound
  logic [5:0] nmi_wait_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_wait_q <= '0;
    else if (!nmi_q || take) nmi_wait_q <= '0;
    else if (nmi_wait_q != 6'h3f) nmi_wait_q <= nmi_wait_q + 6'd1;
  end

  a_r10_nmi_latency: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_wait_q < 6'(LAT_LIMIT));

  a_r5_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nmi_q && !req[win_idx]) |=> !lat_q[$past(win_idx)]);

  a_r3_nmi_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (take && nmi_q && !nmi_req) |=> !nmi_q);
endmodule

// File: rtl/iseq_ctrl.sv
module iseq_ctrl
  import iseq_pkg::*;
#(
  parameter int          NSRC    = 4,
  parameter int          IW      = 2,
  parameter int          DW      = 8,
  parameter int          AW      = 16,
  parameter logic [15:0] VEC_TOP = 16'hFFFE,
  parameter logic [15:0] SP_INIT = 16'h0080
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reti,
  input  logic          imf_set,
  input  logic          imf_clr,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-2:0] psw_flags_in,
  input  logic          pend_ok,
  input  logic          win_nmi,
  input  logic [IW-1:0] win_idx,
  output logic          take,
  output logic          imf,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc_out,
  output logic          pc_load,
  output logic [DW-1:0] psw_out,
  output logic          psw_load,
  output logic          busy,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] FRAME = AW'(FRAME_BYTES);

  seq_state_t    state_q, state_d;
  logic [AW-1:0] sp_q, sp_d, ret_q, ret_d, vec_q, vec_d, pcn_q, pcn_d;
  logic [DW-1:0] psw_q, psw_d, lo_q, lo_d;
  logic          imf_q, imf_d;
  logic [IW:0]   slot;
  logic [AW-1:0] vaddr;

  assign slot  = win_nmi ? '0 : ({1'b0, win_idx} + 1'b1);
  assign vaddr = VEC_TOP - (AW'(slot) << 1) - AW'(2);
  assign take  = (state_q == S_IDLE) && !reti && pend_ok;

  always_comb begin
    state_d = state_q;
    sp_d    = sp_q;
    ret_d   = ret_q;
    vec_d   = vec_q;
    pcn_d   = pcn_q;
    psw_d   = psw_q;
    lo_d    = lo_q;
    unique case (state_q)
      S_IDLE: begin
        if (reti) begin
          state_d = S_POP_PSW;
        end else if (pend_ok) begin
          state_d = S_PUSH_HI;
          ret_d   = pc_in;
          psw_d   = {imf_q, psw_flags_in};
          vec_d   = vaddr;
        end
      end
      S_PUSH_HI:  state_d = S_PUSH_LO;
      S_PUSH_LO:  state_d = S_PUSH_PSW;
      S_PUSH_PSW: begin
        state_d = S_VEC_LO;
        sp_d    = sp_q - FRAME;
      end
      S_VEC_LO: begin
        state_d = S_VEC_HI;
        lo_d    = mem_rdata;
      end
      S_VEC_HI: begin
        state_d = S_ENTER;
        pcn_d   = {mem_rdata, lo_q};
      end
      S_POP_PSW: begin
        state_d = S_POP_LO;
        psw_d   = mem_rdata;
      end
      S_POP_LO: begin
        state_d = S_POP_HI;
        lo_d    = mem_rdata;
      end
      S_POP_HI: begin
        state_d = S_LEAVE;
        pcn_d   = {mem_rdata, lo_q};
        sp_d    = sp_q + FRAME;
      end
      default: state_d = S_IDLE;
    endcase

    if (take)                       imf_d = 1'b0;
    else if (state_q == S_POP_HI)   imf_d = psw_q[DW-1];
    else if (imf_set)               imf_d = 1'b1;
    else if (imf_clr)               imf_d = 1'b0;
    else                            imf_d = imf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sp_q    <= SP_INIT;
      imf_q   <= 1'b0;
      ret_q   <= '0;
      vec_q   <= '0;
      pcn_q   <= '0;
      psw_q   <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      imf_q   <= imf_d;
      ret_q   <= ret_d;
      vec_q   <= vec_d;
      pcn_q   <= pcn_d;
      psw_q   <= psw_d;
      lo_q    <= lo_d;
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    pc_load   = 1'b0;
    psw_load  = 1'b0;
    unique case (state_q)
      S_PUSH_HI:  begin mem_we = 1'b1; mem_addr = sp_q;          mem_wdata = ret_q[AW-1:DW]; end
      S_PUSH_LO:  begin mem_we = 1'b1; mem_addr = sp_q - AW'(1); mem_wdata = ret_q[DW-1:0];  end
      S_PUSH_PSW: begin mem_we = 1'b1; mem_addr = sp_q - AW'(2); mem_wdata = psw_q;          end
      S_VEC_LO:   begin mem_re = 1'b1; mem_addr = vec_q;          end
      S_VEC_HI:   begin mem_re = 1'b1; mem_addr = vec_q + AW'(1); end
      S_POP_PSW:  begin mem_re = 1'b1; mem_addr = sp_q + AW'(1);  end
      S_POP_LO:   begin mem_re = 1'b1; mem_addr = sp_q + AW'(2);  end
      S_POP_HI:   begin mem_re = 1'b1; mem_addr = sp_q + AW'(3);  end
      S_ENTER:    pc_load = 1'b1;
      S_LEAVE:    begin pc_load = 1'b1; psw_load = 1'b1; end
      default:    ;
    endcase
  end

  assign busy    = (state_q != S_IDLE);
  assign imf     = imf_q;
  assign sp      = sp_q;
  assign pc_out  = pcn_q;
  assign psw_out = psw_q;

  a_r1_imf_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !win_nmi) |-> imf_q);

  a_r5_imf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !imf_q);

  a_r6_sp_push: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PUSH_PSW) |=> (sp_q == $past(sp_q) - FRAME));

  a_r8_sp_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_POP_HI) |=> (sp_q == $past(sp_q) + FRAME));

  a_r9_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load) |=> !busy);
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq #(
  parameter int          NSRC    = 4,
  parameter logic [15:0] VEC_TOP = 16'hFFFE,
  parameter logic [15:0] SP_INIT = 16'h0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            nmi_req,
  input  logic [NSRC-1:0] src_en,
  input  logic            imf_set,
  input  logic            imf_clr,
  input  logic            reti,
  input  logic [15:0]     pc_in,
  input  logic [6:0]      psw_flags_in,
  input  logic [7:0]      mem_rdata,
  output logic [15:0]     mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [7:0]      mem_wdata,
  output logic [15:0]     pc_out,
  output logic            pc_load,
  output logic [7:0]      psw_out,
  output logic            psw_load,
  output logic            imf,
  output logic            busy,
  output logic [15:0]     sp
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int DW = 8;
  localparam int AW = 16;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          pend_ok, win_nmi, take;
  logic [IW-1:0] win_idx;

  iseq_pend #(.NSRC(NSRC), .IW(IW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req     (irq_req),
    .nmi_req (nmi_req),
    .en      (src_en),
    .imf     (imf),
    .take    (take),
    .pend_ok (pend_ok),
    .win_nmi (win_nmi),
    .win_idx (win_idx)
  );

  iseq_ctrl #(
    .NSRC(NSRC), .IW(IW), .DW(DW), .AW(AW),
    .VEC_TOP(VEC_TOP), .SP_INIT(SP_INIT)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .reti         (reti),
    .imf_set      (imf_set),
    .imf_clr      (imf_clr),
    .pc_in        (pc_in),
    .psw_flags_in (psw_flags_in),
    .pend_ok      (pend_ok),
    .win_nmi      (win_nmi),
    .win_idx      (win_idx),
    .take         (take),
    .imf          (imf),
    .mem_addr     (mem_addr),
    .mem_we       (mem_we),
    .mem_re       (mem_re),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .pc_out       (pc_out),
    .pc_load      (pc_load),
    .psw_out      (psw_out),
    .psw_load     (psw_load),
    .busy         (busy),
    .sp           (sp)
  );
endmodule

// File: tb/irq_accept_seq_test.sv
module irq_accept_seq_test;
  localparam int NSRC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic nmi_req = 1'b0;
  logic [NSRC-1:0] src_en = '1;
  logic imf_set = 1'b0, imf_clr = 1'b0, reti = 1'b0;
  logic [15:0] pc_in = 16'h4321;
  logic [6:0] psw_flags_in = 7'h05;
  logic [7:0] mem_rdata;
  logic [15:0] mem_addr, pc_out, sp;
  logic mem_we, mem_re, pc_load, psw_load, imf, busy;
  logic [7:0] mem_wdata, psw_out;

  always #4 clk = ~clk;

  irq_accept_seq #(.NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .src_en(src_en), .imf_set(imf_set), .imf_clr(imf_clr), .reti(reti),
    .pc_in(pc_in), .psw_flags_in(psw_flags_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .pc_out(pc_out), .pc_load(pc_load),
    .psw_out(psw_out), .psw_load(psw_load), .imf(imf), .busy(busy), .sp(sp)
  );

  // memory: stack page and vector table
  logic [7:0] stk [256];
  logic [7:0] vtab [16];

  function automatic logic [7:0] vrd(input logic [15:0] a);
    return vtab[a[3:0]];
  endfunction

  always_comb begin
    if (mem_addr[15:8] == 8'h00)      mem_rdata = stk[mem_addr[7:0]];
    else if (mem_addr[15:4] == 12'hFFF) mem_rdata = vtab[mem_addr[3:0]];
    else                                mem_rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (mem_we && mem_addr[15:8] == 8'h00) stk[mem_addr[7:0]] <= mem_wdata;
  end

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // reference model: queue of expected bus cycles
  typedef struct packed {
    logic we, re, pl, psl, rest;
    logic [1:0] kind;
    logic [15:0] addr;
    logic [7:0] wd;
    logic [15:0] pc;
    logic [7:0] psw;
    logic [15:0] spv;
    logic imfv;
  } ent_t;

  ent_t q[$];
  logic [15:0] m_sp = 16'h0080;
  logic m_imf = 1'b0, m_nmi = 1'b0;
  logic [NSRC-1:0] m_lat = '0;

  function automatic ent_t mk(input logic we, re, pl, psl, rest,
                              input logic [1:0] kind, input logic [15:0] addr,
                              input logic [7:0] wd, input logic [15:0] pc,
                              input logic [7:0] psw, input logic [15:0] spv,
                              input logic imfv);
    ent_t e;
    e.we = we; e.re = re; e.pl = pl; e.psl = psl; e.rest = rest;
    e.kind = kind; e.addr = addr; e.wd = wd; e.pc = pc; e.psw = psw;
    e.spv = spv; e.imfv = imfv;
    return e;
  endfunction

  function automatic string tag(input logic [1:0] k);
    case (k)
      2'd0: return "R6";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_sp = 16'h0080; m_imf = 1'b0; m_nmi = 1'b0; m_lat = '0;
    end else begin
      logic acc, nclr, rest, rest_v;
      logic [NSRC-1:0] clr;
      logic [15:0] n, va;
      int slot;
      acc = 0; nclr = 0; rest = 0; rest_v = 0; clr = '0; slot = -1;
      n = m_sp;
      if (q.size() == 0) begin
        if (reti) begin
          q.push_back(mk(0,1,0,0,0,2'd2, n+16'd1, 8'h0, 16'h0, 8'h0, n, 0));
          q.push_back(mk(0,1,0,0,0,2'd2, n+16'd2, 8'h0, 16'h0, 8'h0, n, 0));
          q.push_back(mk(0,1,0,0,1,2'd2, n+16'd3, 8'h0, 16'h0, 8'h0, n,
                         stk[8'(n+16'd1)][7]));
          q.push_back(mk(0,0,1,1,0,2'd2, 16'h0, 8'h0,
                         {stk[8'(n+16'd3)], stk[8'(n+16'd2)]},
                         stk[8'(n+16'd1)], n+16'd3, 0));
          m_sp = n + 16'd3;
        end else begin
          if (m_nmi) slot = 0;
          else if (m_imf)
            for (int i = NSRC - 1; i >= 0; i--)
              if (m_lat[i] && src_en[i]) slot = i + 1;
          if (slot >= 0) begin
            acc = 1;
            if (slot == 0) nclr = 1; else clr[slot-1] = 1'b1;
            va = 16'hFFFE - 16'(2 * (slot + 1));
            q.push_back(mk(1,0,0,0,0,2'd0, n,        pc_in[15:8], 16'h0, 8'h0, n, 0));
            q.push_back(mk(1,0,0,0,0,2'd0, n-16'd1,  pc_in[7:0],  16'h0, 8'h0, n, 0));
            q.push_back(mk(1,0,0,0,0,2'd0, n-16'd2,  {m_imf, psw_flags_in}, 16'h0, 8'h0, n, 0));
            q.push_back(mk(0,1,0,0,0,2'd1, va,       8'h0, 16'h0, 8'h0, n-16'd3, 0));
            q.push_back(mk(0,1,0,0,0,2'd1, va+16'd1, 8'h0, 16'h0, 8'h0, n-16'd3, 0));
            q.push_back(mk(0,0,1,0,0,2'd1, 16'h0, 8'h0, {vrd(va+16'd1), vrd(va)},
                           8'h0, n-16'd3, 0));
            m_sp = n - 16'd3;
          end
        end
      end else begin
        ent_t e;
        e = q.pop_front();
        if (e.rest) begin rest = 1; rest_v = e.imfv; end
      end
      if (acc)          m_imf = 1'b0;
      else if (rest)    m_imf = rest_v;
      else if (imf_set) m_imf = 1'b1;
      else if (imf_clr) m_imf = 1'b0;
      m_lat = (m_lat & ~clr) | irq_req;
      m_nmi = (m_nmi & ~nclr) | nmi_req;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      ent_t e;
      string t;
      if (q.size() == 0) e = mk(0,0,0,0,0,2'd3, 16'h0, 8'h0, 16'h0, 8'h0, m_sp, 0);
      else e = q[0];
      t = tag(e.kind);
      chk(busy == (q.size() != 0), "R9", "busy", busy, q.size() != 0);
      chk(mem_we == e.we, t, "mem_we", mem_we, e.we);
      chk(mem_re == e.re, t, "mem_re", mem_re, e.re);
      if (e.we | e.re) chk(mem_addr == e.addr, t, "mem_addr", mem_addr, e.addr);
      if (e.we) chk(mem_wdata == e.wd, t, "mem_wdata", mem_wdata, e.wd);
      chk(pc_load == e.pl, t, "pc_load", pc_load, e.pl);
      if (e.pl) chk(pc_out == e.pc, t, "pc_out", pc_out, e.pc);
      chk(psw_load == e.psl, t, "psw_load", psw_load, e.psl);
      if (e.psl) chk(psw_out == e.psw, t, "psw_out", psw_out, e.psw);
      chk(sp == e.spv, t, "sp", sp, e.spv);
      chk(imf == m_imf, "R5", "imf", imf, m_imf);
    end
  end

  logic [15:0] hist[$];
  logic [7:0] last_psw = 8'h00;
  always @(posedge clk) begin
    if (rst_n && pc_load) hist.push_back(pc_out);
    if (rst_n && psw_load) last_psw <= psw_out;
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wait_quiet();
    int idle = 0;
    while (idle < 3) begin
      @(negedge clk);
      if (busy) idle = 0; else idle++;
    end
  endtask

  task automatic pulse_req(input logic [NSRC-1:0] v);
    irq_req = v; tick(); irq_req = '0;
  endtask

  task automatic do_reti();
    reti = 1'b1; tick(); reti = 1'b0; wait_quiet();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    for (int i = 0; i < 16; i++) vtab[i] = 8'h00;
    vtab[12] = 8'h34; vtab[13] = 8'h12;   // non-maskable: 1234
    vtab[10] = 8'h03; vtab[11] = 8'hD2;   // source 0: D203
    vtab[8]  = 8'h10; vtab[9]  = 8'hA0;   // source 1: A010
    vtab[6]  = 8'h20; vtab[7]  = 8'hB0;   // source 2: B020
    vtab[4]  = 8'h30; vtab[5]  = 8'hC0;   // source 3: C030
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R11 reset state
    chk(sp == 16'h0080, "R11", "sp", sp, 16'h0080);
    chk(imf == 1'b0, "R11", "imf", imf, 0);
    chk(busy == 1'b0, "R11", "busy", busy, 0);

    // R1: request with global enable off is held
    pulse_req(4'b0010);
    repeat (6) tick();
    chk(hist.size() == 0, "R1", "loads with imf=0", hist.size(), 0);
    imf_set = 1'b1; tick(); imf_set = 1'b0;
    chk(imf == 1'b1, "R12", "imf after set", imf, 1);
    tick();
    reti = 1'b1; tick(); reti = 1'b0;       // R9: ignored while busy
    wait_quiet();
    chk(hist.size() == 1, "R9", "loads after busy reti", hist.size(), 1);
    chk(hist[0] == 16'hA010, "R1", "entry", hist[0], 16'hA010);
    chk(sp == 16'h007D, "R6", "sp after push", sp, 16'h007D);
    do_reti();
    chk(hist[1] == 16'h4321, "R8", "return pc", hist[1], 16'h4321);
    chk(last_psw == 8'h85, "R8", "restored psw", last_psw, 8'h85);
    chk(imf == 1'b1, "R8", "restored imf", imf, 1);
    chk(sp == 16'h0080, "R8", "sp after pop", sp, 16'h0080);

    // R2: disabled source stays pending
    hist.delete();
    src_en = 4'b1110;
    pulse_req(4'b0101);
    wait_quiet();
    chk(hist[0] == 16'hB020, "R2", "enabled source wins", hist[0], 16'hB020);
    do_reti();
    chk(hist.size() == 2, "R2", "disabled held", hist.size(), 2);
    src_en = 4'b1111;
    wait_quiet();
    chk(hist.size() == 3 && hist[2] == 16'hD203, "R2", "late enable", hist[hist.size()-1], 16'hD203);
    do_reti();

    // R4: lowest index first, the other follows the return
    hist.delete();
    pulse_req(4'b1010);
    wait_quiet();
    chk(hist[0] == 16'hA010, "R4", "first winner", hist[0], 16'hA010);
    do_reti();
    chk(hist.size() == 3 && hist[2] == 16'hC030, "R4", "second winner", hist[hist.size()-1], 16'hC030);
    do_reti();

    // R3/R10: non-maskable with imf cleared
    imf_clr = 1'b1; tick(); imf_clr = 1'b0;
    chk(imf == 1'b0, "R12", "imf after clear", imf, 0);
    hist.delete();
    pc_in = 16'h5A6B;
    nmi_req = 1'b1; tick(); nmi_req = 1'b0;
    begin
      int lat = 1;
      while (!busy && lat < 60) begin tick(); lat++; end
      chk(lat <= 38, "R10", "nmi latency", lat, 38);
    end
    wait_quiet();
    chk(hist[0] == 16'h1234, "R3", "nmi entry", hist[0], 16'h1234);
    do_reti();
    chk(hist[1] == 16'h5A6B, "R8", "return pc", hist[1], 16'h5A6B);
    chk(imf == 1'b0, "R8", "restored imf=0", imf, 0);
    pc_in = 16'h4321;

    // R3: nmi beats pending maskable work
    hist.delete();
    pulse_req(4'b0001);
    nmi_req = 1'b1; imf_set = 1'b1; tick(); nmi_req = 1'b0; imf_set = 1'b0;
    wait_quiet();
    chk(hist[0] == 16'h1234, "R3", "nmi first", hist[0], 16'h1234);
    do_reti();
    chk(hist.size() == 3 && hist[2] == 16'hD203, "R3", "maskable after", hist[hist.size()-1], 16'hD203);
    do_reti();

    // R9: return wins over a source that becomes eligible the same cycle
    hist.delete();
    src_en = 4'b1110;
    pulse_req(4'b0100);
    wait_quiet();
    pulse_req(4'b0001);
    imf_set = 1'b1; tick(); imf_set = 1'b0;
    tick();
    src_en = 4'b1111; reti = 1'b1; tick(); reti = 1'b0;
    wait_quiet();
    chk(hist.size() == 3, "R9", "load count", hist.size(), 3);
    chk(hist[1] == 16'h4321, "R9", "return first", hist[1], 16'h4321);
    chk(hist[2] == 16'hD203, "R9", "then accept", hist[2], 16'hD203);
    do_reti();
    chk(sp == 16'h0080, "R8", "final sp", sp, 16'h0080);
    finish_run();
  end
endmodule